// File: doc/BRIEF.md
# Codec Input Frame Receiver

This block sits on the controller side of an AC'97-style serial link and turns the codec's serial input stream back into words. It runs entirely on the link bit clock and samples both the frame marker and the data line on the falling edge. A frame starts on the first falling edge at which the marker is seen high after having been low. Each frame is 256 bits long. The first 16 bits form a tag slot, and twelve data slots of 20 bits each follow it. Every field arrives most significant bit first.

The tag slot carries three things. The codec-ready flag comes first. It is followed by one valid tag for each of the twelve data slots, and then by three bits that are thrown away. The receiver polls the ready flag in every frame and presents it to host logic. A data slot is presented on the parallel output only when three conditions hold: its tag is set, the frame's own ready flag is 1, and it is not the reserved twelfth slot. The output carries the slot number and the 20-bit payload, qualified by a one-cycle strobe. A frame marker that rises at the wrong bit count raises a framing-error pulse, and the receiver realigns to that new edge.

Top module: `codec_in_rx`

## Requirements
- R1: While rst is high, ready, slot_vld and frame_err are all driven to 0.
- R2: Frame bit 0 is the bit sampled on the first falling bit_clk edge where sync_in is 1 and was 0 on the edge before. The frame then runs for 16 + 12*20 = 256 consecutive sampled bits.
- R3: On the edge of frame bit 0, ready takes the value of sdin. It holds that value until bit 0 of the next frame and can return to 0.
- R4: Frame bit k, for k = 1..12, is the valid tag for data slot k. Data slot k occupies frame bits 16+20*(k-1) through 15+20*k, with its payload MSB first.
- R5: When slot k is emitted, slot_vld is high for exactly one cycle, starting right after the edge that samples the slot's last bit. During that cycle slot_num is k in unsigned binary and slot_data holds the payload.
- R6: No slot is emitted in a frame whose bit 0 was 0.
- R7: Slot 12 is never emitted, even when its tag is 1.
- R8: A slot whose tag is 0 is not emitted. Frame bits 13 to 15 have no effect on any output.
- R9: When sync_in rises while a frame is in progress and before its bit 255 has been sampled, frame_err pulses high for one cycle. The new edge becomes frame bit 0, and the slot that was cut short is not emitted.
- R10: When the edge after frame bit 255 shows no sync_in rise, the receiver goes idle. It then emits nothing and flags no error until the next rise, and that next rise starts a frame without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Link bit clock; all logic acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame marker from the link |
| sdin | input | 1 | Serial input data from the codec |
| ready | output | 1 | Codec-ready flag from the most recent frame |
| slot_vld | output | 1 | One-cycle strobe for an emitted slot |
| slot_num | output | 4 | Number of the emitted slot, 1 to 12 |
| slot_data | output | 20 | Payload of the emitted slot |
| frame_err | output | 1 | One-cycle pulse on a misplaced frame start |

## Verification
Two checker properties assume that sync_in is low throughout reset and during the cycle before reset is released, so that the first rise after reset is a real low-to-high step. The ready-timing property also assumes that sync_in never rises on two edges in a row, which any marker at least one bit wide satisfies. The stimulus keeps sync_in low in reset and always drives it high for 16 bits at a time. Truncated frames are always cut after bit 16, so sync_in has already dropped before the next frame raises it again.

// File: rtl/cirx_pkg.sv
package cirx_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int DATA_SLOTS = 12;
  localparam int RSV_SLOT   = 12;
endpackage

// File: rtl/cirx_framer.sv
module cirx_framer #(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int DATA_SLOTS = 12,
  localparam int SW = $clog2(DATA_SLOTS + 1),
  localparam int BW = $clog2((SLOT_BITS > TAG_BITS) ? SLOT_BITS : TAG_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  output logic          nx_live,
  output logic [SW-1:0] nx_slot,
  output logic [BW-1:0] nx_bit,
  output logic          frame_err
);
  logic          sync_d;
  logic          lock;
  logic [SW-1:0] cur_slot;
  logic [BW-1:0] cur_bit;
  logic          rise;
  logic          slot_last;
  logic          at_end;
  logic          early;

  assign rise      = sync_in & ~sync_d;
  assign slot_last = (cur_slot == '0) ? (cur_bit == BW'(TAG_BITS - 1))
                                      : (cur_bit == BW'(SLOT_BITS - 1));
  assign at_end    = lock && slot_last && (cur_slot == SW'(DATA_SLOTS));

  always_comb begin
    nx_live = 1'b0;
    nx_slot = cur_slot;
    nx_bit  = cur_bit;
    early   = 1'b0;
    if (rise) begin
      nx_live = 1'b1;
      nx_slot = '0;
      nx_bit  = '0;
      early   = lock && !at_end;
    end else if (lock && !at_end) begin
      nx_live = 1'b1;
      if (slot_last) begin
        nx_slot = cur_slot + 1'b1;
        nx_bit  = '0;
      end else begin
        nx_bit = cur_bit + 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      sync_d    <= 1'b0;
      lock      <= 1'b0;
      cur_slot  <= '0;
      cur_bit   <= '0;
      frame_err <= 1'b0;
    end else begin
      sync_d    <= sync_in;
      lock      <= nx_live;
      cur_slot  <= nx_slot;
      cur_bit   <= nx_bit;
      frame_err <= early;
    end
  end
endmodule

// File: rtl/cirx_tagreg.sv
module cirx_tagreg #(
  parameter int DATA_SLOTS = 12,
  parameter int SW = 4,
  parameter int BW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                live,
  input  logic [SW-1:0]       slot,
  input  logic [BW-1:0]       bitn,
  input  logic                sdin,
  output logic                ready,
  output logic [DATA_SLOTS:0] tag
);
  logic in_tag_slot;
  assign in_tag_slot = live && (slot == '0);
  assign tag[0] = 1'b0;

  always_ff @(negedge clk) begin
    if (rst) ready <= 1'b0;
    else if (in_tag_slot && bitn == '0) ready <= sdin;
  end

  for (genvar g = 1; g <= DATA_SLOTS; g++) begin : g_tag
    always_ff @(negedge clk) begin
      if (rst) tag[g] <= 1'b0;
      else if (in_tag_slot && bitn == BW'(g)) tag[g] <= sdin;
    end
  end
endmodule

// File: rtl/cirx_slotcap.sv
module cirx_slotcap #(
  parameter int SLOT_BITS  = 20,
  parameter int DATA_SLOTS = 12,
  parameter int RSV_SLOT   = 12,
  parameter int SW = 4,
  parameter int BW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 live,
  input  logic [SW-1:0]        slot,
  input  logic [BW-1:0]        bitn,
  input  logic                 sdin,
  input  logic                 ready,
  input  logic [DATA_SLOTS:0]  tag,
  output logic                 vld,
  output logic [SW-1:0]        num,
  output logic [SLOT_BITS-1:0] data
);
  logic [SLOT_BITS-1:0] shift;
  logic [SLOT_BITS-1:0] word;
  logic                 in_data;
  logic                 fire;

  assign in_data = live && (slot != '0);
  assign word    = {shift[SLOT_BITS-2:0], sdin};
  assign fire    = in_data && (bitn == BW'(SLOT_BITS - 1)) && ready &&
                   tag[slot] && (slot != SW'(RSV_SLOT));

  always_ff @(negedge clk) begin
    if (rst) begin
      shift <= '0;
      vld   <= 1'b0;
      num   <= '0;
      data  <= '0;
    end else begin
      vld <= fire;
      if (in_data) shift <= word;
      if (fire) begin
        num  <= slot;
        data <= word;
      end
    end
  end
endmodule

// File: rtl/codec_in_rx.sv
module codec_in_rx
  import cirx_pkg::*;
#(
  parameter int TB = TAG_BITS,
  parameter int DB = SLOT_BITS,
  parameter int NS = DATA_SLOTS,
  parameter int RS = RSV_SLOT,
  localparam int SW = $clog2(NS + 1),
  localparam int BW = $clog2((DB > TB) ? DB : TB)
) (
  input  logic          bit_clk,
  input  logic          rst,
  input  logic          sync_in,
  input  logic          sdin,
  output logic          ready,
  output logic          slot_vld,
  output logic [SW-1:0] slot_num,
  output logic [DB-1:0] slot_data,
  output logic          frame_err
);
  logic          live;
  logic [SW-1:0] pslot;
  logic [BW-1:0] pbit;
  logic [NS:0]   tag;

  cirx_framer #(.TAG_BITS(TB), .SLOT_BITS(DB), .DATA_SLOTS(NS)) u_framer (
    .clk(bit_clk), .rst(rst), .sync_in(sync_in),
    .nx_live(live), .nx_slot(pslot), .nx_bit(pbit), .frame_err(frame_err)
  );

  cirx_tagreg #(.DATA_SLOTS(NS), .SW(SW), .BW(BW)) u_tag (
    .clk(bit_clk), .rst(rst), .live(live), .slot(pslot), .bitn(pbit),
    .sdin(sdin), .ready(ready), .tag(tag)
  );

  cirx_slotcap #(.SLOT_BITS(DB), .DATA_SLOTS(NS), .RSV_SLOT(RS),
                 .SW(SW), .BW(BW)) u_cap (
    .clk(bit_clk), .rst(rst), .live(live), .slot(pslot), .bitn(pbit),
    .sdin(sdin), .ready(ready), .tag(tag),
    .vld(slot_vld), .num(slot_num), .data(slot_data)
  );
endmodule

// File: rtl/codec_in_rx_chk.sv
module codec_in_rx_chk #(
  parameter int NS = 12,
  parameter int RS = 12,
  parameter int SW = 4
) (
  input logic          bit_clk,
  input logic          rst,
  input logic          sync_in,
  input logic          ready,
  input logic          slot_vld,
  input logic [SW-1:0] slot_num,
  input logic          frame_err
);
  assert_num_range_R5: assert property (@(negedge bit_clk) disable iff (rst)
    slot_vld |-> (slot_num >= SW'(1) && slot_num <= SW'(NS)));

  assert_strobe_single_R5: assert property (@(negedge bit_clk) disable iff (rst)
    slot_vld |=> !slot_vld);

  assert_gated_by_ready_R6: assert property (@(negedge bit_clk) disable iff (rst)
    slot_vld |-> ready);

  assert_no_reserved_R7: assert property (@(negedge bit_clk) disable iff (rst)
    slot_vld |-> (slot_num != SW'(RS)));

  assert_err_pulse_R9: assert property (@(negedge bit_clk) disable iff (rst)
    frame_err |=> !frame_err);

  assert_err_on_rise_R9: assert property (@(negedge bit_clk) disable iff (rst)
    frame_err |-> ($past(sync_in) && !$past(sync_in, 2)));

  assert_ready_at_start_R3: assert property (@(negedge bit_clk) disable iff (rst)
    !$stable(ready) |-> ($past(sync_in) && !$past(sync_in, 2)));
endmodule

bind codec_in_rx codec_in_rx_chk #(.NS(NS), .RS(RS), .SW(SW)) u_chk (
  .bit_clk(bit_clk), .rst(rst), .sync_in(sync_in), .ready(ready),
  .slot_vld(slot_vld), .slot_num(slot_num), .frame_err(frame_err)
);

// File: tb/test_codec_in_rx.sv
`timescale 1ns/1ps
module test_codec_in_rx;
  logic        bit_clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_in = 1'b0;
  logic        sdin = 1'b0;
  logic        ready;
  logic        slot_vld;
  logic [3:0]  slot_num;
  logic [19:0] slot_data;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int errs_seen = 0;
  bit done = 0;

  int m_pos = -1;
  bit m_prev = 0;
  bit m_ready = 0;
  bit m_tag [13];
  int m_sh = 0;
  bit e_vld = 0;
  bit e_err = 0;
  int e_num = 0;
  int e_data = 0;

  always #2.5 bit_clk = ~bit_clk;

  codec_in_rx i_codec_in_rx (
    .bit_clk(bit_clk), .rst(rst), .sync_in(sync_in), .sdin(sdin),
    .ready(ready), .slot_vld(slot_vld), .slot_num(slot_num),
    .slot_data(slot_data), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit s, input bit d);
    bit rise;
    int k;
    e_vld = 0;
    e_err = 0;
    rise = s && !m_prev;
    m_prev = s;
    if (rise) begin
      if (m_pos != -1 && m_pos != 255) e_err = 1;
      m_pos = 0;
    end else if (m_pos == 255) m_pos = -1;
    else if (m_pos != -1) m_pos++;
    if (m_pos == 0) m_ready = d;
    else if (m_pos >= 1 && m_pos <= 12) m_tag[m_pos] = d;
    else if (m_pos >= 16) begin
      m_sh = ((m_sh << 1) | int'(d)) & 32'hFFFFF;
      k = (m_pos - 16) / 20 + 1;
      if ((m_pos - 16) % 20 == 19 && m_tag[k] && m_ready && k != 12) begin
        e_vld = 1;
        e_num = k;
        e_data = m_sh;
      end
    end
  endtask

  task automatic compare();
    if (slot_vld) strobes++;
    if (frame_err) errs_seen++;
    chk(ready == m_ready, "R3 ready", ready, m_ready);
    chk(slot_vld == e_vld, "R5 slot_vld", slot_vld, e_vld);
    if (e_vld && slot_vld) begin
      chk(int'(slot_num) == e_num, "R4 slot_num", slot_num, e_num);
      chk(int'(slot_data) == e_data, "R2 R4 slot_data", slot_data, e_data);
    end
    chk(frame_err == e_err, "R9 frame_err", frame_err, e_err);
  endtask

  task automatic bitx(input bit s, input bit d);
    @(posedge bit_clk);
    compare();
    sync_in = s;
    sdin = d;
    model_step(s, d);
  endtask

  task automatic send_frame(input bit rdy, input bit [12:1] tg, input bit [2:0] junk,
                            input int nbits, input int seed);
    bit fb [256];
    bit [19:0] w;
    fb[0] = rdy;
    for (int k = 1; k <= 12; k++) fb[k] = tg[k];
    fb[13] = junk[2]; fb[14] = junk[1]; fb[15] = junk[0];
    for (int s = 1; s <= 12; s++) begin
      w = 20'(seed * 7919 + s * 40503) ^ 20'hA5A5A;
      for (int b = 0; b < 20; b++) fb[16 + 20 * (s - 1) + b] = w[19 - b];
    end
    for (int i = 0; i < nbits; i++) bitx(i < 16, fb[i]);
  endtask

  initial begin
    for (int i = 0; i < 13; i++) m_tag[i] = 0;
    repeat (3) @(posedge bit_clk);
    @(posedge bit_clk);
    chk(ready == 0, "R1 ready in reset", ready, 0);
    chk(slot_vld == 0, "R1 slot_vld in reset", slot_vld, 0);
    chk(frame_err == 0, "R1 frame_err in reset", frame_err, 0);
    rst = 0;
    bitx(0, 1);
    bitx(0, 0);

    strobes = 0;
    send_frame(0, 12'hFFF, 3'b000, 256, 1);
    send_frame(0, 12'hFFF, 3'b101, 256, 2);
    bitx(0, 0);
    chk(strobes == 0, "R6 no emission while not ready", strobes, 0);
    chk(ready == 0, "R3 ready stays low", ready, 0);

    strobes = 0;
    send_frame(1, 12'hFFF, 3'b000, 256, 3);
    bitx(0, 0);
    chk(strobes == 11, "R5 R7 all tags set", strobes, 11);
    chk(ready == 1, "R3 ready rises", ready, 1);

    strobes = 0;
    send_frame(1, 12'b1000_0010_0101, 3'b111, 256, 4);
    bitx(0, 0);
    chk(strobes == 3, "R8 R7 sparse tags", strobes, 3);

    strobes = 0;
    errs_seen = 0;
    send_frame(1, 12'hFFF, 3'b010, 100, 5);
    send_frame(1, 12'hFFF, 3'b000, 256, 6);
    bitx(0, 0);
    chk(strobes == 15, "R9 truncated then full", strobes, 15);
    chk(errs_seen == 1, "R9 one framing error", errs_seen, 1);

    strobes = 0;
    errs_seen = 0;
    send_frame(1, 12'hFFF, 3'b000, 256, 7);
    for (int i = 0; i < 7; i++) bitx(0, i[0]);
    send_frame(1, 12'hFFF, 3'b000, 256, 8);
    bitx(0, 0);
    chk(strobes == 22, "R10 gap between frames", strobes, 22);
    chk(errs_seen == 0, "R10 no error after gap", errs_seen, 0);

    strobes = 0;
    send_frame(0, 12'hFFF, 3'b000, 256, 9);
    bitx(0, 0);
    chk(strobes == 0, "R6 ready lost", strobes, 0);
    chk(ready == 0, "R3 ready falls", ready, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule